// File: doc/BRIEF.md
# Serial Configuration Port with Pin-Strapped Standalone Mode

This block is the control slave of a mixed-signal audio device. A host reaches a bank of 8-bit configuration registers over four wires: a serial clock, an active-low frame latch, a serial data input and a serial data output. Each transfer is a 24-bit frame sent most significant bit first. The first byte holds a 7-bit device identifier followed by a direction flag. The second byte selects the register. The third byte carries the data, coming from the host on a write or from the block on a read. The serial pins need not be related to any audio clock. They are brought into the system clock domain through synchronizer chains, and all frame decoding runs on the system clock, so the register outputs are already synchronous.

While reset is held, the block samples the serial pins to pick its operating mode. If the serial clock, the data input and the latch are all low, the device enters standalone operation. In that case no host is present and the serial port is disabled. Every register takes its default, except that the internal master-clock enable is set. The level seen on the data-output pin then selects whether the ADC serial clocks are generated locally (master) or taken from outside (slave). Otherwise the block runs in host mode. In both modes, once reset is released and the PLL reports lock, a sequencer counts a fixed number of master-clock cycles and then raises a ready flag.

The frame engine has five states. IDLE waits with the latch high. It moves to HEADER when the latch is low and host mode is active. HEADER counts the first 16 rising clock edges. After the 8th edge it moves to DROP if the identifier does not match, and after the 16th edge it moves to DATA. DATA moves to FULL after the 24th rising edge. FULL moves to DROP on any further rising edge. Every state returns to IDLE when the latch rises. A write is committed only when the latch rises while the engine is in FULL. The init sequencer has three states: WAIT_LOCK moves to COUNT when lock is high, and COUNT moves to READY when the count expires. READY holds until reset.

Top module: `cfg_spi_port`

## Requirements
- R1: After reset in host mode, every register reads 0x00 on `cfg_regs`, `sdo_oe` is low, `standalone` is low and `ready` is low.
- R2: A frame of exactly 24 bits is written into the addressed register when the latch rises. The bits are sampled on rising serial clock edges, MSB first. The first byte is 0x08 (identifier 0x04 in bits 7:1, bit 0 = 0 for write), then the register address, then the data.
- R3: A frame whose first byte is 0x09 (bit 0 = 1) is a read. From the falling clock edge that ends the 16th bit, `sdo_oe` is high and `sdo` presents the addressed register MSB first, advancing on each falling edge. `sdo_oe` is low in every write frame and after the latch rises.
- R4: A frame whose first-byte bits 7:1 differ from 0x04 changes no register and never enables `sdo`.
- R5: A frame that ends with the latch rising after fewer or more than 24 rising clock edges changes no register.
- R6: A write changes only the addressed register. All others keep their values, so clearing the power-down bit (bit 0) of one section register leaves the other sections untouched.
- R7: A write to an address of NREG or above changes no register, and a read of such an address returns 0x00.
- R8: If the serial clock, data input and latch are all low during reset, `standalone` is high after reset. Register 0 then reads 0x80, with the master-clock enable in bit 7, and serial frames have no effect.
- R9: In standalone mode, register 2 bit 6 (ADC clock master) equals the level of `sdo_pin_in` during reset, and all other bits of register 2 are 0.
- R10: `ready` stays low until `pll_lock` has been high after reset. It rises INIT_CYCLES cycles after lock, give or take two cycles, and stays high until the next reset.
- R11: With the latch high during reset, the block starts in host mode and register 2 reads 0x00 whatever the level of `sdo_pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System / master clock |
| rst_n | input | 1 | Synchronous active-low reset; strap pins are sampled while it is low |
| pll_lock | input | 1 | PLL lock indication, synchronous to clk |
| sclk | input | 1 | Serial clock from the host |
| latch_n | input | 1 | Active-low frame latch |
| sdi | input | 1 | Serial data in |
| sdo_pin_in | input | 1 | Level sensed on the data-output pin, used as a strap during reset |
| sdo | output | 1 | Serial data out (valid while sdo_oe is high) |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |
| standalone | output | 1 | Standalone mode was selected at reset |
| ready | output | 1 | Post-reset initialization finished |
| cfg_regs | output | NREG*8 | All configuration registers, register i in bits 8i+7:8i |

## Verification
On every cycle, the assertions check four things: the output enable drops after each latch rise, no write strobe appears except out of the FULL state, no register changes unless it is the write target, and the mode strap and the ready flag are stable once set. Only the bench's frames can show the rest: that the bits are assembled in the right order, that the identifier, length and address filters drop exactly the frames they should, that read data leaves MSB first in time for the host's rising edges, and that the strap pins give the right defaults in each mode.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

    localparam logic [6:0] DEV_ID        = 7'h04;
    localparam int         CLK_REG       = 0;
    localparam int         ADC_REG       = 2;
    localparam int         MCLK_EN_BIT   = 7;
    localparam int         ADC_MSTR_BIT  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_DATA,
        ST_FULL,
        ST_DROP
    } frame_state_t;

    typedef enum logic [1:0] {
        IN_WAIT_LOCK,
        IN_COUNT,
        IN_READY
    } init_state_t;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            chain <= {chain[STAGES-2:0], din[b]};
        end
        assign dout[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import cfg_spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       latch_low,
    input  logic       latch_rise,
    input  logic       sclk_rise,
    input  logic       sclk_fall,
    input  logic       sdi_bit,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_addr,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sdo,
    output logic       sdo_oe
);
    frame_state_t st_q, st_d;
    logic [4:0]   bit_cnt;
    logic [7:0]   shreg;
    logic [7:0]   addr_q;
    logic [7:0]   out_sh;
    logic         is_read;
    logic [7:0]   byte_in;

    assign byte_in = {shreg[6:0], sdi_bit};
    assign rd_addr = addr_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (enable && latch_low) st_d = ST_HEADER;
            ST_HEADER: if (sclk_rise) begin
                           if (bit_cnt == 5'd7 && byte_in[7:1] != DEV_ID) st_d = ST_DROP;
                           else if (bit_cnt == 5'd15)                     st_d = ST_DATA;
                       end
            ST_DATA:   if (sclk_rise && bit_cnt == 5'd23) st_d = ST_FULL;
            ST_FULL:   if (sclk_rise) st_d = ST_DROP;
            ST_DROP:   st_d = ST_DROP;
            default:   st_d = ST_IDLE;
        endcase
        if (latch_rise || !enable) st_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            addr_q  <= '0;
            is_read <= 1'b0;
        end else if (st_q == ST_IDLE) begin
            bit_cnt <= '0;
        end else if (sclk_rise && st_q != ST_DROP) begin
            shreg   <= byte_in;
            bit_cnt <= bit_cnt + 5'd1;
            if (bit_cnt == 5'd7)  is_read <= sdi_bit;
            if (bit_cnt == 5'd15) addr_q  <= byte_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            sdo_oe  <= 1'b0;
            out_sh  <= '0;
        end else begin
            wr_en   <= (st_q == ST_FULL) && latch_rise && !is_read && enable;
            wr_addr <= addr_q;
            wr_data <= shreg;
            if (latch_rise || st_d == ST_DROP || st_q == ST_IDLE) begin
                sdo_oe <= 1'b0;
            end else if (sclk_fall && st_q == ST_DATA && bit_cnt == 5'd16 && is_read) begin
                sdo_oe <= 1'b1;
                out_sh <= rd_data;
            end else if (sclk_fall && sdo_oe) begin
                out_sh <= {out_sh[6:0], 1'b0};
            end
        end
    end

    assign sdo = sdo_oe & out_sh[7];

    // R3
    oe_off_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_rise |=> !sdo_oe);
    // R5
    wr_from_full_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(st_q) == ST_FULL);
    // R4
    drop_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DROP && !latch_rise && enable) |=> st_q == ST_DROP);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_spi_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strap_sa,
    input  logic            strap_master,
    input  logic            standalone,
    input  logic            wr_en,
    input  logic [7:0]      wr_addr,
    input  logic [7:0]      wr_data,
    input  logic [7:0]      rd_addr,
    output logic [7:0]      rd_data,
    output logic [NREG*8-1:0] regs_flat
);
    logic [7:0] regs_q [NREG];

    function automatic logic [7:0] default_of(int idx, logic sa, logic mstr);
        logic [7:0] v;
        v = 8'h00;
        if (sa && idx == CLK_REG) v[MCLK_EN_BIT]  = 1'b1;
        if (sa && idx == ADC_REG) v[ADC_MSTR_BIT] = mstr;
        return v;
    endfunction

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                            regs_q[i] <= default_of(i, strap_sa, strap_master);
            else if (wr_en && wr_addr == 8'(i))    regs_q[i] <= wr_data;
        end
        assign regs_flat[i*8 +: 8] = regs_q[i];

        // R6
        untouched_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == 8'(i)) |=> $stable(regs_q[i]));
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++) begin
            if (rd_addr == 8'(i)) rd_data = regs_q[i];
        end
    end

    // R8
    sa_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standalone |-> !wr_en);
endmodule

// File: rtl/init_seq.sv
module init_seq
    import cfg_spi_pkg::*;
#(
    parameter int INIT_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock,
    output logic ready
);
    localparam int CW = $clog2(INIT_CYCLES + 1);

    init_state_t st_q, st_d;
    logic [CW-1:0] cnt;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IN_WAIT_LOCK: if (lock) st_d = IN_COUNT;
            IN_COUNT:     if (lock && cnt == CW'(INIT_CYCLES - 1)) st_d = IN_READY;
            IN_READY:     st_d = IN_READY;
            default:      st_d = IN_WAIT_LOCK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= IN_WAIT_LOCK;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else begin
            if (st_q == IN_COUNT && lock) cnt <= cnt + CW'(1);
            ready <= (st_d == IN_READY);
        end
    end

    // R10
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    // R10
    ready_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(lock));
endmodule

// File: rtl/cfg_spi_port.sv
module cfg_spi_port
    import cfg_spi_pkg::*;
#(
    parameter int NREG        = 16,
    parameter int SYNC_STAGES = 2,
    parameter int INIT_CYCLES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_lock,
    input  logic              sclk,
    input  logic              latch_n,
    input  logic              sdi,
    input  logic              sdo_pin_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              standalone,
    output logic              ready,
    output logic [NREG*8-1:0] cfg_regs
);
    logic [3:0] pins_s;
    logic       sclk_s, latch_s, sdi_s, sdo_pin_s;
    logic       sclk_p, latch_p;
    logic       strap_sa_now;
    logic       sa_q, mstr_q;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

    pin_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  ({sdo_pin_in, sdi, latch_n, sclk}),
        .dout (pins_s)
    );
    assign {sdo_pin_s, sdi_s, latch_s, sclk_s} = pins_s;

    always_ff @(posedge clk) begin
        sclk_p  <= sclk_s;
        latch_p <= latch_s;
    end

    assign strap_sa_now = !sclk_s && !sdi_s && !latch_s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sa_q   <= strap_sa_now;
            mstr_q <= sdo_pin_s;
        end
    end
    assign standalone = sa_q;

    spi_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (!sa_q),
        .latch_low  (!latch_s),
        .latch_rise (latch_s && !latch_p),
        .sclk_rise  (sclk_s && !sclk_p),
        .sclk_fall  (!sclk_s && sclk_p),
        .sdi_bit    (sdi_s),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe)
    );

    cfg_reg_bank #(.NREG(NREG)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_sa     (strap_sa_now),
        .strap_master (sdo_pin_s),
        .standalone   (sa_q),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .regs_flat    (cfg_regs)
    );

    init_seq #(.INIT_CYCLES(INIT_CYCLES)) u_init (
        .clk   (clk),
        .rst_n (rst_n),
        .lock  (pll_lock),
        .ready (ready)
    );

    // R8
    strap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(sa_q));
endmodule

// File: tb/cfg_spi_port_test.sv
module cfg_spi_port_test;
    localparam int NREG = 16;
    localparam int INIT = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pll_lock = 1'b0;
    logic sclk = 1'b0, latch_n = 1'b1, sdi = 1'b0, sdo_pin_in = 1'b0;
    logic sdo, sdo_oe, standalone, ready;
    logic [NREG*8-1:0] cfg_regs;

    int total = 0, bad = 0;
    logic [7:0] model [NREG];

    always #10 clk = ~clk;

    cfg_spi_port #(.NREG(NREG), .INIT_CYCLES(INIT)) uut (
        .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .sclk(sclk), .latch_n(latch_n),
        .sdi(sdi), .sdo_pin_in(sdo_pin_in), .sdo(sdo), .sdo_oe(sdo_oe),
        .standalone(standalone), .ready(ready), .cfg_regs(cfg_regs)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic w8();
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [23:0] mk(input logic [7:0] id, input logic rd, input logic [7:0] a, input logic [7:0] d);
        return {id[6:0], rd, a, d};
    endfunction

    task automatic frame(input logic [23:0] w, input int nbits, output logic [7:0] rb, output bit oe_seen);
        rb = 8'h00;
        oe_seen = 1'b0;
        sclk = 1'b0;
        latch_n = 1'b0;
        w8();
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 24) ? w[23 - i] : 1'b0;
            w8();
            if (sdo_oe) oe_seen = 1'b1;
            if (i >= 16 && i < 24) rb[23 - i] = sdo;
            sclk = 1'b1;
            w8();
            sclk = 1'b0;
        end
        w8();
        latch_n = 1'b1;
        repeat (16) @(negedge clk);
        if (sdo_oe) oe_seen = 1'b1;
    endtask

    task automatic do_reset(input logic c, input logic l, input logic d, input logic o);
        rst_n = 1'b0;
        sclk = c; latch_n = l; sdi = d; sdo_pin_in = o;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sclk = 1'b0; latch_n = 1'b1; sdi = 1'b0; sdo_pin_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic cmp_all(input string req);
        for (int i = 0; i < NREG; i++)
            check(cfg_regs[i*8 +: 8] == model[i], req, 32'(cfg_regs[i*8 +: 8]), 32'(model[i]));
    endtask

    function automatic logic [7:0] exp_read(input int a);
        return (a < NREG) ? model[a] : 8'h00;
    endfunction

    initial begin
        #(20 * 190000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        bit oe;
        void'($urandom(32'd4711));
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;

        // R1 reset state in host mode
        do_reset(1'b0, 1'b1, 1'b0, 1'b0);
        cmp_all("R1");
        check(!sdo_oe && !standalone && !ready, "R1", {sdo_oe, standalone, ready}, 0);

        // R10 ready waits for lock
        repeat (300) @(negedge clk);
        check(!ready, "R10", ready, 0);
        pll_lock = 1'b1;
        repeat (250) @(negedge clk);
        check(!ready, "R10", ready, 0);
        repeat (20) @(negedge clk);
        check(ready, "R10", ready, 1);

        // R2 basic write
        frame(mk(8'h04, 1'b0, 8'd3, 8'hA5), 24, rb, oe);
        model[3] = 8'hA5;
        cmp_all("R2");
        check(!oe, "R3", oe, 0);

        // R3 read back
        frame(mk(8'h04, 1'b1, 8'd3, 8'h00), 24, rb, oe);
        check(rb == 8'hA5, "R3", rb, 8'hA5);
        check(oe, "R3", oe, 1);
        check(!sdo_oe, "R3", sdo_oe, 0);

        // R6 power-down bits of sections are independent
        frame(mk(8'h04, 1'b0, 8'd0, 8'h01), 24, rb, oe); model[0] = 8'h01;
        frame(mk(8'h04, 1'b0, 8'd1, 8'h01), 24, rb, oe); model[1] = 8'h01;
        frame(mk(8'h04, 1'b0, 8'd2, 8'h01), 24, rb, oe); model[2] = 8'h01;
        frame(mk(8'h04, 1'b0, 8'd1, 8'h00), 24, rb, oe); model[1] = 8'h00;
        cmp_all("R6");

        // R4 wrong device identifier
        frame(mk(8'h05, 1'b0, 8'd4, 8'h3C), 24, rb, oe);
        cmp_all("R4");
        frame(mk(8'h05, 1'b1, 8'd3, 8'h00), 24, rb, oe);
        check(!oe, "R4", oe, 0);

        // R5 short and long frames
        frame(mk(8'h04, 1'b0, 8'd5, 8'h77), 23, rb, oe);
        cmp_all("R5");
        frame(mk(8'h04, 1'b0, 8'd5, 8'h77), 25, rb, oe);
        cmp_all("R5");

        // R7 out-of-range address
        frame(mk(8'h04, 1'b0, 8'(NREG), 8'hEE), 24, rb, oe);
        cmp_all("R7");
        frame(mk(8'h04, 1'b1, 8'(NREG + 3), 8'h00), 24, rb, oe);
        check(rb == 8'h00, "R7", rb, 0);

        // R2 R3 R4 R5 R7 random traffic
        for (int n = 0; n < 60; n++) begin
            int op, a;
            logic [7:0] d;
            op = int'($urandom_range(0, 7));
            a  = int'($urandom_range(0, NREG + 1));
            d  = 8'($urandom);
            if (op <= 3) begin
                frame(mk(8'h04, 1'b0, 8'(a), d), 24, rb, oe);
                if (a < NREG) model[a] = d;
                cmp_all("R2");
            end else if (op <= 5) begin
                frame(mk(8'h04, 1'b1, 8'(a), d), 24, rb, oe);
                check(rb == exp_read(a), "R3", rb, exp_read(a));
            end else if (op == 6) begin
                frame(mk(8'h0C, 1'b0, 8'(a), d), 24, rb, oe);
                cmp_all("R4");
            end else begin
                frame(mk(8'h04, 1'b0, 8'(a), d), (n % 2) ? 16 : 26, rb, oe);
                cmp_all("R5");
            end
        end

        // R1 reset restores defaults
        do_reset(1'b0, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        cmp_all("R1");
        // R11 latch high: host mode, strap on sdo pin ignored
        check(!standalone, "R11", standalone, 0);
        check(cfg_regs[2*8 +: 8] == 8'h00, "R11", cfg_regs[2*8 +: 8], 0);

        // R8 R9 standalone, master strap
        do_reset(1'b0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        model[0] = 8'h80; model[2] = 8'h40;
        check(standalone, "R8", standalone, 1);
        cmp_all("R9");
        frame(mk(8'h04, 1'b0, 8'd3, 8'h55), 24, rb, oe);
        cmp_all("R8");
        check(!oe, "R8", oe, 0);

        // R9 slave strap
        do_reset(1'b0, 1'b0, 1'b0, 1'b0);
        model[2] = 8'h00;
        check(standalone, "R8", standalone, 1);
        cmp_all("R9");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule